// File: doc/BRIEF.md
# Control Endpoint Buffer Status Tracker

This block keeps the readiness state of the two buffers that serve a USB device's control endpoint: the IN buffer that firmware fills for the host, and the OUT buffer that receives host data and SETUP packets. Firmware drives it through an 8-bit command code with a one-cycle valid strobe. The packet engine drives it through one-cycle event pulses: IN token seen, IN packet fully sent, OUT data stored, and SETUP stored.

A validate command arms the IN buffer. The next IN token then produces a one-cycle transmit enable. The length of the buffer plays no part, so an empty buffer that has been validated goes out as a zero-length packet. A validate is refused while the OUT side carries an unread SETUP or an overwrite mark. A refusal pulses a reject flag and leaves the IN state alone. Any SETUP disarms the IN buffer, because the control transfer it belonged to has been abandoned. A clear command releases the OUT buffer and reports in bit 0 of a status byte whether a SETUP overwrote earlier, unread data.

Top module: `ctl_ep_buf_tracker`

## Requirements
- R1: After reset, `in_ready`, `tx_go`, `val_refused` and `clr_status` are all 0.
- R2: A command with code 0xFA (validate) is accepted when no SETUP is pending, the overwrite mark is clear, and no SETUP event arrives in the same cycle. When accepted, `in_ready` is 1 from the next cycle on.
- R3: Once set, `in_ready` stays 1 through any number of IN tokens. Only an IN-sent event or a SETUP event clears it, and the clear shows in the next cycle.
- R4: `tx_go` is 1 for exactly one cycle, in the cycle after an IN token that arrives while `in_ready` is 1 and no SETUP event arrives in the same cycle. An IN token arriving while `in_ready` is 0 produces no `tx_go`. No byte count takes part in this decision, so a buffer validated while empty is sent as a zero-length packet.
- R5: A validate is refused while the overwrite mark (status bit 0) is set.
- R6: A validate is refused while a SETUP is pending, or when a SETUP event arrives in the same cycle. On a refusal, `val_refused` is 1 for exactly the next cycle, and the validate itself does not change `in_ready`.
- R7: A SETUP event clears `in_ready` in the next cycle. This takes priority over an IN-sent event or a validate in the same cycle.
- R8: A SETUP event sets the overwrite mark when the OUT buffer already holds uncleared data, either OUT data or an earlier SETUP. Every SETUP marks a SETUP as pending.
- R9: A command with code 0xF2 (clear) empties the OUT buffer, clears the pending SETUP and clears the overwrite mark. From the next cycle on, `clr_status` holds {7'b0, overwrite mark before the clear}, and bits 7:1 are always 0. If a SETUP event arrives in the same cycle as a clear, the buffer counts as empty before that SETUP: the SETUP becomes pending and no overwrite mark is set.
- R10: A command with any other code, or a code presented without `cmd_valid`, changes no output and no state.
- R11: An accepted validate in the same cycle as an IN-sent event leaves `in_ready` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_code | input | 8 | Command code |
| ev_in_token | input | 1 | IN token received |
| ev_in_sent | input | 1 | IN packet fully transmitted |
| ev_out_data | input | 1 | OUT data stored in the OUT buffer |
| ev_setup | input | 1 | SETUP packet stored |
| in_ready | output | 1 | IN buffer full and armed for sending |
| tx_go | output | 1 | One-cycle transmit enable for the packet engine |
| val_refused | output | 1 | One-cycle pulse on a refused validate |
| clr_status | output | 8 | Status byte from the last clear; bit 0 is the overwrite mark |

## Verification
The checker evaluates several rules on every cycle. A SETUP empties the IN side on the next cycle. A transmit enable always follows an IN token that arrived while the buffer was full. A rise of `in_ready` always follows a validate. A refusal never appears without a validate, and the upper status bits stay zero. Other properties depend on a sequence of events, and only the bench's scenarios bring them out: the overwrite mark appears only after OUT data or a second SETUP, the status byte returns the mark from before the clear, and the same-cycle collisions between SETUP, clear, validate and IN-sent resolve as required. The bench's reference model covers all of these on every clock.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;

  typedef struct packed {
    logic validate;
    logic clear;
  } cmd_hit_t;

  // Decode one command strobe against the two recognised codes.
  function automatic cmd_hit_t decode_cmd(input logic       valid,
                                          input logic [7:0] code,
                                          input logic [7:0] val_code,
                                          input logic [7:0] clr_code);
    cmd_hit_t h;
    h.validate = valid && (code == val_code);
    h.clear    = valid && (code == clr_code);
    return h;
  endfunction

  // A SETUP overwrites when anything still sits in the OUT buffer
  // after a same-cycle clear has been applied.
  function automatic logic overwrite_hit(input logic setup,
                                         input logic clear,
                                         input logic occupied);
    return setup && !clear && occupied;
  endfunction

endpackage

// File: rtl/ctl_ep_cmd_dec.sv
module ctl_ep_cmd_dec #(
  parameter int CMD_W = 8,
  parameter logic [CMD_W-1:0] VAL_CODE = 8'hFA,
  parameter logic [CMD_W-1:0] CLR_CODE = 8'hF2
) (
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_code,
  output logic             is_validate,
  output logic             is_clear
);
  import ctl_ep_pkg::*;
  cmd_hit_t hit;
  always_comb begin
    hit         = decode_cmd(cmd_valid, cmd_code, VAL_CODE, CLR_CODE);
    is_validate = hit.validate;
    is_clear    = hit.clear;
  end
endmodule

// File: rtl/ctl_ep_out_side.sv
module ctl_ep_out_side #(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_clear,
  input  logic              ev_out_data,
  input  logic              ev_setup,
  output logic              block_validate,
  output logic              ow_mark,
  output logic [STAT_W-1:0] status
);
  import ctl_ep_pkg::*;
  localparam int PAD_W = STAT_W - 1;

  logic occ_q, pend_q, ow_q;
  logic occ_eff, pend_eff, ow_eff;

  // State after a same-cycle clear, before new events are applied.
  always_comb begin
    occ_eff  = is_clear ? 1'b0 : occ_q;
    pend_eff = is_clear ? 1'b0 : pend_q;
    ow_eff   = is_clear ? 1'b0 : ow_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_q  <= 1'b0;
      pend_q <= 1'b0;
      ow_q   <= 1'b0;
      status <= '0;
    end else begin
      occ_q  <= occ_eff | ev_out_data | ev_setup;
      pend_q <= pend_eff | ev_setup;
      ow_q   <= ow_eff | overwrite_hit(ev_setup, is_clear, occ_q | pend_q);
      if (is_clear) status <= {{PAD_W{1'b0}}, ow_q};
    end
  end

  assign block_validate = ow_q | pend_q | ev_setup;
  assign ow_mark        = ow_q;
endmodule

// File: rtl/ctl_ep_in_side.sv
module ctl_ep_in_side (
  input  logic clk,
  input  logic rst_n,
  input  logic is_validate,
  input  logic block_validate,
  input  logic ev_in_token,
  input  logic ev_in_sent,
  input  logic ev_setup,
  output logic full,
  output logic tx_go,
  output logic refused,
  output logic accept_w
);
  logic full_q, tx_q, ref_q;
  logic refuse_w;

  assign accept_w = is_validate && !block_validate;
  assign refuse_w = is_validate &&  block_validate;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      tx_q   <= 1'b0;
      ref_q  <= 1'b0;
    end else begin
      if (ev_setup)        full_q <= 1'b0;
      else if (accept_w)   full_q <= 1'b1;
      else if (ev_in_sent) full_q <= 1'b0;
      tx_q  <= ev_in_token && full_q && !ev_setup;
      ref_q <= refuse_w;
    end
  end

  assign full    = full_q;
  assign tx_go   = tx_q;
  assign refused = ref_q;
endmodule

// File: rtl/ctl_ep_buf_tracker.sv
module ctl_ep_buf_tracker #(
  parameter int CMD_W = 8,
  parameter int STAT_W = 8,
  parameter logic [CMD_W-1:0] VAL_CODE = 8'hFA,
  parameter logic [CMD_W-1:0] CLR_CODE = 8'hF2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_code,
  input  logic              ev_in_token,
  input  logic              ev_in_sent,
  input  logic              ev_out_data,
  input  logic              ev_setup,
  output logic              in_ready,
  output logic              tx_go,
  output logic              val_refused,
  output logic [STAT_W-1:0] clr_status
);
  // Named internal events, visible to the checker.
  logic is_validate, is_clear, block_validate, ow_mark, accept_w;

  ctl_ep_cmd_dec #(.CMD_W(CMD_W), .VAL_CODE(VAL_CODE), .CLR_CODE(CLR_CODE)) u_dec (
    .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .is_validate(is_validate), .is_clear(is_clear)
  );

  ctl_ep_out_side #(.STAT_W(STAT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .is_clear(is_clear),
    .ev_out_data(ev_out_data), .ev_setup(ev_setup),
    .block_validate(block_validate), .ow_mark(ow_mark), .status(clr_status)
  );

  ctl_ep_in_side u_in (
    .clk(clk), .rst_n(rst_n), .is_validate(is_validate),
    .block_validate(block_validate), .ev_in_token(ev_in_token),
    .ev_in_sent(ev_in_sent), .ev_setup(ev_setup),
    .full(in_ready), .tx_go(tx_go), .refused(val_refused), .accept_w(accept_w)
  );
endmodule

// File: rtl/ctl_ep_buf_tracker_chk.sv
module ctl_ep_buf_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_in_token,
  input logic       ev_in_sent,
  input logic       ev_setup,
  input logic       is_validate,
  input logic       ow_mark,
  input logic       in_ready,
  input logic       tx_go,
  input logic       val_refused,
  input logic [7:0] clr_status
);
  assert_setup_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_setup |=> !in_ready);

  assert_tx_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go |-> $past(ev_in_token && in_ready && !ev_setup));

  assert_rise_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $past(is_validate));

  assert_refuse_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    val_refused |-> $past(is_validate) && !$rose(in_ready));

  assert_ow_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_validate && ow_mark) |=> val_refused);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !ev_in_sent && !ev_setup) |=> in_ready);

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_status[7:1] == 7'b0);
endmodule

bind ctl_ep_buf_tracker ctl_ep_buf_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_in_token(ev_in_token), .ev_in_sent(ev_in_sent),
  .ev_setup(ev_setup), .is_validate(is_validate), .ow_mark(ow_mark),
  .in_ready(in_ready), .tx_go(tx_go), .val_refused(val_refused),
  .clr_status(clr_status)
);

// File: tb/test_ctl_ep_buf_tracker.sv
module test_ctl_ep_buf_tracker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_code = 8'h00;
  logic ev_in_token = 1'b0, ev_in_sent = 1'b0, ev_out_data = 1'b0, ev_setup = 1'b0;
  logic in_ready, tx_go, val_refused;
  logic [7:0] clr_status;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ctl_ep_buf_tracker i_ctl_ep_buf_tracker (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .ev_in_token(ev_in_token), .ev_in_sent(ev_in_sent), .ev_out_data(ev_out_data),
    .ev_setup(ev_setup), .in_ready(in_ready), .tx_go(tx_go),
    .val_refused(val_refused), .clr_status(clr_status)
  );

  // Reference model, written from the requirements.
  int m_full = 0, m_tx = 0, m_ref = 0, m_stat = 0;
  int m_stored = 0, m_pending = 0, m_over = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_full = 0; m_tx = 0; m_ref = 0; m_stat = 0;
      m_stored = 0; m_pending = 0; m_over = 0;
    end else begin
      int val, clr, prev_over, busy;
      val = (cmd_valid && cmd_code == 8'hFA) ? 1 : 0;
      clr = (cmd_valid && cmd_code == 8'hF2) ? 1 : 0;
      prev_over = m_over;
      m_tx = (ev_in_token && m_full && !ev_setup) ? 1 : 0;
      m_ref = 0;
      if (val) begin
        if (m_over || m_pending || ev_setup) m_ref = 1;
        else m_full = 1;
      end
      if (ev_in_sent && !val) m_full = 0;
      if (ev_in_sent && val && m_ref) m_full = 0;
      if (ev_setup) m_full = 0;
      if (clr) begin
        m_stat = prev_over;
        m_stored = 0; m_pending = 0; m_over = 0;
      end
      busy = m_stored || m_pending;
      if (ev_setup) begin
        if (busy) m_over = 1;
        m_pending = 1;
        m_stored = 1;
      end
      if (ev_out_data) m_stored = 1;
    end
  end

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      cmp("R3", "in_ready vs model", in_ready, m_full);
      cmp("R4", "tx_go vs model", tx_go, m_tx);
      cmp("R6", "val_refused vs model", val_refused, m_ref);
      cmp("R9", "clr_status vs model", clr_status, m_stat);
    end
  end

  task automatic step(input bit v, input logic [7:0] code, input bit tok,
                      input bit sent, input bit od, input bit su);
    @(negedge clk); #1;
    cmd_valid = v; cmd_code = code; ev_in_token = tok;
    ev_in_sent = sent; ev_out_data = od; ev_setup = su;
    @(negedge clk); #1;
    cmd_valid = 0; cmd_code = 8'h00; ev_in_token = 0;
    ev_in_sent = 0; ev_out_data = 0; ev_setup = 0;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp("R1", "in_ready at reset", in_ready, 0);
    cmp("R1", "tx_go at reset", tx_go, 0);
    cmp("R1", "val_refused at reset", val_refused, 0);
    cmp("R1", "clr_status at reset", clr_status, 0);
    #1 rst_n = 1;

    // R2/R4: validate an empty buffer, then an IN token sends a zero-length packet
    step(1, 8'hFA, 0, 0, 0, 0);
    cmp("R2", "in_ready after validate", in_ready, 1);
    step(0, 8'h00, 1, 0, 0, 0);
    cmp("R4", "tx_go after token", tx_go, 1);
    step(0, 8'h00, 0, 0, 0, 0);
    cmp("R4", "tx_go single cycle", tx_go, 0);
    cmp("R3", "in_ready held across token", in_ready, 1);
    step(0, 8'h00, 0, 1, 0, 0);
    cmp("R3", "in_ready cleared by sent", in_ready, 0);
    step(0, 8'h00, 1, 0, 0, 0);
    cmp("R4", "no tx_go when empty", tx_go, 0);

    // R10: other codes, and the code without its strobe
    step(1, 8'hF0, 0, 0, 0, 0);
    cmp("R10", "in_ready after unknown code", in_ready, 0);
    step(0, 8'hFA, 0, 0, 0, 0);
    cmp("R10", "code without valid", in_ready, 0);

    // R6/R8: SETUP with an empty OUT buffer -> pending, validate refused
    step(0, 8'h00, 0, 0, 0, 1);
    step(1, 8'hFA, 0, 0, 0, 0);
    cmp("R6", "refused while pending", val_refused, 1);
    cmp("R6", "in_ready unchanged", in_ready, 0);
    step(1, 8'hF2, 0, 0, 0, 0);
    cmp("R8", "no overwrite from lone setup", clr_status, 0);

    // R8/R5/R9: OUT data then SETUP -> overwrite mark
    step(0, 8'h00, 0, 0, 1, 0);
    step(0, 8'h00, 0, 0, 0, 1);
    step(1, 8'hFA, 0, 0, 0, 0);
    cmp("R5", "refused while overwrite set", val_refused, 1);
    step(1, 8'hF2, 0, 0, 0, 0);
    cmp("R9", "status carries overwrite", clr_status, 1);
    step(1, 8'hF2, 0, 0, 0, 0);
    cmp("R9", "second clear reads intact", clr_status, 0);

    // R7: SETUP beats IN-sent and the token in the same cycle
    step(1, 8'hFA, 0, 0, 0, 0);
    step(0, 8'h00, 1, 1, 0, 1);
    cmp("R7", "setup clears in_ready", in_ready, 0);
    cmp("R7", "no tx_go with setup", tx_go, 0);
    // R9: clear together with SETUP -> pending, no overwrite
    step(1, 8'hF2, 0, 0, 0, 1);
    step(1, 8'hF2, 0, 0, 0, 0);
    cmp("R9", "clear+setup leaves no overwrite", clr_status, 0);

    // R11: validate together with IN-sent
    step(1, 8'hFA, 0, 0, 0, 0);
    step(1, 8'hFA, 0, 1, 0, 0);
    cmp("R11", "validate wins over sent", in_ready, 1);
    // R6: validate with a same-cycle SETUP is refused
    step(1, 8'hFA, 0, 0, 0, 1);
    cmp("R6", "refused with same-cycle setup", val_refused, 1);
    cmp("R7", "in_ready cleared", in_ready, 0);

    step(0, 8'h00, 0, 0, 0, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule